// File: doc/BRIEF.md
# Packed word to byte stream unpacker

This block turns a stream of 32-bit packed words into a stream of bytes. Each word describes its own length through marker bytes in its upper lanes, and can carry one, two, three or four bytes of payload. The block accepts one word at a time on a valid/ready input and then presents its payload bytes one after another on a valid/ready output. The first byte out is always bits 7:0, and each later byte comes from the next higher lane.

Each input word comes with a 4-bit channel tag. That tag travels with every byte taken from the word. A last-byte flag marks the final byte of each word, so a downstream consumer can find word boundaries. The block holds exactly one word. It does not take the next word until the current word has been fully drained.

Top module: `word_byte_unpacker`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A word whose bits 31:8 equal 0x808080 produces exactly one byte, equal to bits 7:0.
- R3: A word whose bits 31:16 equal 0x8181 produces exactly two bytes, in the order bits 7:0 then bits 15:8.
- R4: A word whose bits 31:24 equal 0x82 produces exactly three bytes, in the order bits 7:0, bits 15:8, then bits 23:16.
- R5: Any other word produces four bytes, from bits 7:0 up to bits 31:24. This includes words whose upper lanes only partly match a marker (for example 0x8180xxxx, 0x808081xx or 0x83xxxxxx).
- R6: out_valid rises on the cycle after an input handshake.
- R7: in_ready stays 0 from the input handshake until the handshake on the final byte of that word. in_ready is 1 again on the following cycle.
- R8: While out_valid is 1 and out_ready is 0, out_byte, out_tag and out_last hold their values.
- R9: Every output byte carries the channel tag that came with its source word.
- R10: out_last is 1 on the final byte of a word and 0 on every earlier byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Packed input word |
| in_tag | input | TAG_W | Channel tag of the input word |
| out_valid | output | 1 | Output byte is offered |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Current payload byte |
| out_tag | output | TAG_W | Channel tag of the current byte |
| out_last | output | 1 | Current byte is the last one of its word |

## Verification
The sweep covers five groups of words:
- Exact one-byte, two-byte and three-byte markers, each paired with varied payload lanes, to show that the correct byte count is recovered.
- Near-miss markers, to separate true markers from words that only partly match one and must fall back to four bytes.
- Arbitrary high-lane words.

The tag changes from word to word, so a stale tag would be caught. The output ready signal follows a repeating stall pattern, so the bench observes bytes both under back-pressure and under immediate acceptance. This shows that the byte index advances only on a handshake and that the input stays closed until the last byte of the word has been taken.

// File: rtl/word_byte_unpacker.sv
module word_byte_unpacker #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_word,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  output logic [TAG_W-1:0] out_tag,
  output logic             out_last
);

  logic             full_q;
  logic [31:0]      word_q;
  logic [TAG_W-1:0] tag_q;
  logic [1:0]       idx_q;
  logic [1:0]       top_q;
  logic [1:0]       top_d;

  always_comb begin
    if (in_word[31:8] == 24'h808080)
      top_d = 2'd0;
    else if (in_word[31:16] == 16'h8181)
      top_d = 2'd1;
    else if (in_word[31:24] == 8'h82)
      top_d = 2'd2;
    else
      top_d = 2'd3;
  end

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_tag   = tag_q;
  assign out_last  = (idx_q == top_q);
  assign out_byte  = word_q[{idx_q, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
      tag_q  <= '0;
      idx_q  <= '0;
      top_q  <= '0;
    end else if (!full_q) begin
      if (in_valid) begin
        full_q <= 1'b1;
        word_q <= in_word;
        tag_q  <= in_tag;
        idx_q  <= '0;
        top_q  <= top_d;
      end
    end else if (out_ready) begin
      if (out_last)
        full_q <= 1'b0;
      else
        idx_q <= idx_q + 2'd1;
    end
  end

endmodule

module word_byte_unpacker_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_byte,
  input logic [TAG_W-1:0] out_tag,
  input logic             out_last
);

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_reopen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_byte) && $stable(out_tag) && $stable(out_last)));

  p_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> $stable(out_tag));

  p_more_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_valid);

endmodule

bind word_byte_unpacker word_byte_unpacker_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
  .out_tag(out_tag), .out_last(out_last)
);

// File: tb/word_byte_unpacker_bench.sv
module word_byte_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [3:0]  in_tag = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_byte;
  logic [3:0]  out_tag;
  logic        out_last;

  int n_chk = 0;
  int n_fail = 0;
  int stall_ph = 0;

  always #4 clk = ~clk;

  word_byte_unpacker #(.TAG_W(4)) u_word_byte_unpacker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_tag(in_tag), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .out_tag(out_tag),
    .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_count(input logic [31:0] w);
    if (w[31:8] == 24'h808080) return 1;
    if (w[31:16] == 16'h8181) return 2;
    if (w[31:24] == 8'h82) return 3;
    return 4;
  endfunction

  function automatic string req_of(input int n);
    case (n)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_word(input logic [31:0] w, input logic [3:0] t);
    int n;
    int got;
    int wait_c;
    logic [7:0] held;
    bit was_stall;
    n = exp_count(w);
    @(negedge clk);
    chk(in_ready == 1'b1, "R7", in_ready, 1);
    in_word = w;
    in_tag = t;
    in_valid = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R6", out_valid, 1);
    got = 0;
    wait_c = 0;
    was_stall = 1'b0;
    held = '0;
    while (got < n && wait_c < 40) begin
      wait_c++;
      if (was_stall)
        chk(out_byte == held, "R8", out_byte, held);
      out_ready = ((stall_ph % 3) != 0);
      stall_ph++;
      chk(out_valid == 1'b1, req_of(n), out_valid, 1);
      chk(in_ready == 1'b0, "R7", in_ready, 0);
      if (out_ready) begin
        chk(out_byte == w[got*8 +: 8], req_of(n), out_byte, w[got*8 +: 8]);
        chk(out_tag == t, "R9", out_tag, t);
        chk(out_last == (got == n-1), "R10", out_last, (got == n-1));
        got++;
        was_stall = 1'b0;
      end else begin
        held = out_byte;
        was_stall = 1'b1;
      end
      @(negedge clk);
    end
    chk(got == n, req_of(n), got, n);
    out_ready = 1'b1;
    chk(out_valid == 1'b0, req_of(n), out_valid, 0);
    chk(in_ready == 1'b1, "R7", in_ready, 1);
    out_ready = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] a;
      logic [7:0] b;
      logic [7:0] c;
      logic [7:0] d;
      a = 8'(k * 16 + 3);
      b = 8'(k * 11 + 5);
      c = 8'(k * 7 + 200);
      d = 8'(k * 13 + 1);
      run_word({24'h808080, a}, 4'(k));
      run_word({16'h8181, b, a}, 4'(k + 1));
      run_word({8'h82, c, b, a}, 4'(k + 2));
      run_word({d, c, b, a}, 4'(k + 3));
      run_word({8'h81, 8'h80, b, a}, 4'(k + 4));
      run_word({16'h8080, 8'h81, a}, 4'(k + 5));
      run_word({8'h83, c, b, a}, 4'(k + 6));
      run_word({8'h80, 8'h81, 8'h81, a}, 4'(k + 7));
      run_word({8'h81, 8'h82, b, a}, 4'(k + 8));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule